// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates six interrupt sources for a small 8-bit microcontroller core and turns the winning request into a call: a one-cycle acknowledge pulse, a strobe that tells the core to push its program counter, and a fixed 8-bit vector address. The sources are two external pins, two timer overflows, an oscillation-converter overflow and an A/D end-of-conversion event. A request flag and an enable bit for each source, plus one global master enable, live in two byte-wide control registers on the core's register bus. The program counter is the only state saved on a call. The accumulator and the status register are never pushed.

Requests are examined only on a phase strobe (`t2_tick`) from the core. A request is accepted when the master enable, the source's own enable and a not-full stack all hold on that strobe. On acceptance the controller clears that source's flag and the master enable, so a service routine is not nested unless software enables nesting itself. The interrupt-return strobe sets the master enable again. A plain return leaves it unchanged. While the stack is full, enabled requests keep their flags and are taken at the first strobe after the stack has room.

The controller is built around a two-state machine. `ST_WAIT` is the idle state that arbitrates on each strobe. `ST_ACK` presents the call for exactly one cycle. The machine moves from `ST_WAIT` to `ST_ACK` (transition "take") when `t2_tick` is high and at least one source is eligible. It moves from `ST_ACK` back to `ST_WAIT` (transition "done") on the following cycle unconditionally. The machine does not stay in `ST_ACK` for two cycles.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, the master enable is clear and `irq_ack` is low.
- R2: Control register A is at address 0x0B and control register B is at address 0x1E. Register A holds the master enable in bit 0, the enables for external-0, external-1 and timer-0 in bits 1, 2 and 3, and their flags in bits 4, 5 and 6. Register B holds the enables for the RC converter, timer-1 and A/D in bits 1, 2 and 3, and their flags in bits 4, 5 and 6. Bit 7 of both registers and bit 0 of register B read 0. Writes to any other address change nothing. Software can both set and clear any flag.
- R3: A request is acknowledged only when, on a cycle with `t2_tick` high, all three of the following hold: the master enable is set, the source's enable is set, and `stack_full` is low. `irq_ack` and `pc_push` then go high together in the cycle that follows that clock edge, for exactly one cycle.
- R4: When several requests are eligible at once, the highest-priority source is served. The priority order, with vectors, is: external-0 (0x04), external-1 (0x08), timer-0 (0x0C), RC converter (0x10), timer-1 (0x14), A/D (0x18). `irq_vector` carries the vector while `irq_ack` is high.
- R5: An acknowledgment clears only the served source's flag, and it clears the master enable. All other flags and all enables are unchanged.
- R6: Events that arrive while the master enable is clear still set their flags. The flags stay pending and are served once the master enable is set.
- R7: While `stack_full` is high, no acknowledgment is made and pending flags stay set. The first strobe after `stack_full` falls serves them.
- R8: A flag set between two strobes is not served until the next strobe.
- R9: `reti_strobe` sets the master enable. `ret_strobe` leaves it unchanged.
- R10: For each external pin, `ext_rise_sel` bit = 1 selects the low-to-high transition and bit = 0 selects the high-to-low transition. Only the selected transition sets that pin's flag.
- R11: A hardware event and a software write to the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t2_tick | input | 1 | Sampling strobe; arbitration happens only when this is high |
| ext_pin | input | 2 | External interrupt pins (bit 0 = external-0) |
| ext_rise_sel | input | 2 | Per-pin edge option: 1 = rising, 0 = falling |
| tmr0_ovf | input | 1 | Timer-0 overflow event pulse |
| rcc_ovf | input | 1 | RC oscillation converter overflow event pulse |
| tmr1_ovf | input | 1 | Timer-1 overflow event pulse |
| adc_done | input | 1 | A/D end-of-conversion event pulse |
| stack_full | input | 1 | Call stack has no free entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ret_strobe | input | 1 | Plain return executed |
| reti_strobe | input | 1 | Interrupt return executed |
| irq_ack | output | 1 | One-cycle call request to the core |
| irq_vector | output | 8 | Vector address, valid with irq_ack |
| pc_push | output | 1 | Push the program counter, asserted with irq_ack |

## Verification
The properties rely on the following assumptions about the core:
- `ret_strobe` and `reti_strobe` are single-cycle pulses.
- The core does not raise `reti_strobe` in the same cycle as an acknowledgment.
- Event inputs are single-cycle pulses synchronous to `clk`.

The directed stimulus follows these rules. It drives every input, including the strobes, for exactly one cycle from the falling clock edge. It never returns while `irq_ack` is high. It holds `ext_rise_sel` constant from before reset is released. Stack-full behaviour is checked by holding `stack_full` across whole strobe periods, never by toggling it between a strobe and the acknowledge it would produce.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NSRC        = 6;
    localparam int SRC_PER_REG = 3;
    localparam int IDXW        = $clog2(NSRC);
    localparam int FLAG_LSB    = 4;
    localparam int EN_LSB      = 1;
    localparam int VEC_STEP    = 4;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_ACK  = 1'b1
    } irq_state_t;

    function automatic logic [7:0] vec_of(input logic [IDXW-1:0] idx);
        return 8'((int'(idx) + 1) * VEC_STEP);
    endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    input  logic [NPIN-1:0] rise_sel,
    output logic [NPIN-1:0] edge_hit
);
    logic [NPIN-1:0] pin_q;
    logic            armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
            armed <= 1'b0;
        end else begin
            pin_q <= pin;
            armed <= 1'b1;
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign edge_hit[g] = armed & (rise_sel[g] ? (pin[g] & ~pin_q[g])
                                                  : (~pin[g] & pin_q[g]));
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import prio_irq_pkg::*;
#(
    parameter logic [7:0] ADDR_A = 8'h0B,
    parameter logic [7:0] ADDR_B = 8'h1E
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [NSRC-1:0] hw_set,
    input  logic            ack_clr,
    input  logic [IDXW-1:0] ack_idx,
    input  logic            reti,
    output logic [NSRC-1:0] flag,
    output logic [NSRC-1:0] en,
    output logic            gie
);
    localparam int NREG = (NSRC + SRC_PER_REG - 1) / SRC_PER_REG;

    logic [NREG-1:0] wsel;
    logic [7:0]      img [NREG];

    always_comb begin
        wsel[0] = wr && (addr == ADDR_A);
        wsel[1] = wr && (addr == ADDR_B);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= '0;
            en   <= '0;
            gie  <= 1'b0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (wsel[i / SRC_PER_REG]) begin
                    flag[i] <= wdata[FLAG_LSB + i % SRC_PER_REG];
                    en[i]   <= wdata[EN_LSB + i % SRC_PER_REG];
                end
                if (ack_clr && ack_idx == IDXW'(i)) flag[i] <= 1'b0;
                if (hw_set[i]) flag[i] <= 1'b1;
            end
            if (wsel[0]) gie <= wdata[0];
            if (reti)    gie <= 1'b1;
            if (ack_clr) gie <= 1'b0;
        end
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) img[r] = 8'h00;
        img[0][0] = gie;
        for (int i = 0; i < NSRC; i++) begin
            img[i / SRC_PER_REG][FLAG_LSB + i % SRC_PER_REG] = flag[i];
            img[i / SRC_PER_REG][EN_LSB + i % SRC_PER_REG]   = en[i];
        end
        if (addr == ADDR_A)      rdata = img[0];
        else if (addr == ADDR_B) rdata = img[1];
        else                     rdata = 8'h00;
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import prio_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter logic [7:0] ADDR_A = 8'h0B,
    parameter logic [7:0] ADDR_B = 8'h1E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       t2_tick,
    input  logic [1:0] ext_pin,
    input  logic [1:0] ext_rise_sel,
    input  logic       tmr0_ovf,
    input  logic       rcc_ovf,
    input  logic       tmr1_ovf,
    input  logic       adc_done,
    input  logic       stack_full,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ret_strobe,
    input  logic       reti_strobe,
    output logic       irq_ack,
    output logic [7:0] irq_vector,
    output logic       pc_push
);
    irq_state_t      state_q;
    logic [IDXW-1:0] idx_q;
    logic [1:0]      ext_hit;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] flag;
    logic [NSRC-1:0] en;
    logic            gie;
    logic [NSRC-1:0] pend;
    logic            pend_any;
    logic [IDXW-1:0] pend_idx;

    irq_edge_det #(.NPIN(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .rise_sel (ext_rise_sel),
        .edge_hit (ext_hit)
    );

    // Source order is the priority order, index 0 highest.
    assign hw_set = {adc_done, tmr1_ovf, rcc_ovf, tmr0_ovf, ext_hit};

    irq_regs #(.ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .hw_set  (hw_set),
        .ack_clr (irq_ack),
        .ack_idx (idx_q),
        .reti    (reti_strobe),
        .flag    (flag),
        .en      (en),
        .gie     (gie)
    );

    assign pend = flag & en & {NSRC{gie & ~stack_full}};

    irq_arb u_arb (
        .pend (pend),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    // State register: ST_WAIT -take-> ST_ACK -done-> ST_WAIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (t2_tick && pend_any) begin
                        state_q <= ST_ACK;
                        idx_q   <= pend_idx;
                    end
                end
                ST_ACK: state_q <= ST_WAIT;
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        irq_ack    = 1'b0;
        pc_push    = 1'b0;
        irq_vector = 8'h00;
        unique case (state_q)
            ST_WAIT: ;
            ST_ACK: begin
                irq_ack    = 1'b1;
                pc_push    = 1'b1;
                irq_vector = vec_of(idx_q);
            end
            default: ;
        endcase
    end

    logic unused_ret;
    assign unused_ret = ret_strobe;
endmodule

module prio_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       t2_tick,
    input logic       stack_full,
    input logic       ret_strobe,
    input logic       reti_strobe,
    input logic       reg_wr,
    input logic       irq_ack,
    input logic       pc_push,
    input logic [7:0] irq_vector,
    input logic       gie
);
    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R3
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> pc_push);

    // R7
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(t2_tick && !stack_full && gie));

    // R4
    vector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_vector inside {8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18}));

    // R5
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);

    // R9
    reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_strobe && !irq_ack) |=> gie);

    // R9
    ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !reti_strobe && !irq_ack && !reg_wr) |=> $stable(gie));
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .t2_tick     (t2_tick),
    .stack_full  (stack_full),
    .ret_strobe  (ret_strobe),
    .reti_strobe (reti_strobe),
    .reg_wr      (reg_wr),
    .irq_ack     (irq_ack),
    .pc_push     (pc_push),
    .irq_vector  (irq_vector),
    .gie         (gie)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam logic [7:0] RA = 8'h0B;
    localparam logic [7:0] RB = 8'h1E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t2_tick = 1'b0;
    logic [1:0] ext_pin = 2'b00;
    logic [1:0] ext_rise_sel = 2'b01;
    logic       tmr0_ovf = 1'b0, rcc_ovf = 1'b0, tmr1_ovf = 1'b0, adc_done = 1'b0;
    logic       stack_full = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ret_strobe = 1'b0, reti_strobe = 1'b0;
    logic       irq_ack, pc_push;
    logic [7:0] irq_vector;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .t2_tick(t2_tick), .ext_pin(ext_pin),
        .ext_rise_sel(ext_rise_sel), .tmr0_ovf(tmr0_ovf), .rcc_ovf(rcc_ovf),
        .tmr1_ovf(tmr1_ovf), .adc_done(adc_done), .stack_full(stack_full),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ret_strobe(ret_strobe), .reti_strobe(reti_strobe),
        .irq_ack(irq_ack), .irq_vector(irq_vector), .pc_push(pc_push)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d cycles expected finish", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic tick_exp(input bit exp_ack, input logic [7:0] exp_vec, input string req);
        @(negedge clk);
        t2_tick = 1'b1;
        @(negedge clk);
        t2_tick = 1'b0;
        chk(req, irq_ack, exp_ack);
        if (exp_ack) begin
            chk(req, irq_vector, exp_vec);
            chk(req, pc_push, 1'b1);
        end
        @(negedge clk);
        chk(req, irq_ack, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", irq_ack, 1'b0);
        rd_chk(RA, 8'h00, "R1");
        rd_chk(RB, 8'h00, "R1");
    endtask

    task automatic t_regmap();
        wr(RA, 8'hFF);
        rd_chk(RA, 8'h7F, "R2");
        wr(RB, 8'hFF);
        rd_chk(RB, 8'h7E, "R2");
        wr(8'h0C, 8'h00);
        rd_chk(RA, 8'h7F, "R2");
        rd_chk(8'h0C, 8'h00, "R2");
        wr(RA, 8'h00);
        wr(RB, 8'h00);
        rd_chk(RA, 8'h00, "R2");
        rd_chk(RB, 8'h00, "R2");
    endtask

    task automatic t_single();
        wr(RB, 8'h04);
        wr(RA, 8'h01);
        @(negedge clk); tmr1_ovf = 1'b1;
        @(negedge clk); tmr1_ovf = 1'b0;
        rd_chk(RB, 8'h24, "R3");
        tick_exp(1'b1, 8'h14, "R3");
        rd_chk(RB, 8'h04, "R5");
        rd_chk(RA, 8'h00, "R5");
        wr(RB, 8'h00);
    endtask

    task automatic t_priority();
        wr(RB, 8'h7E);
        wr(RA, 8'h7F);
        for (int i = 0; i < 6; i++) begin
            tick_exp(1'b1, 8'((i + 1) * 4), "R4");
            @(negedge clk); reti_strobe = 1'b1;
            @(negedge clk); reti_strobe = 1'b0;
        end
        rd_chk(RA, 8'h0F, "R5");
        rd_chk(RB, 8'h0E, "R5");
        wr(RA, 8'h00);
        wr(RB, 8'h00);
    endtask

    task automatic t_masked();
        wr(RA, 8'h08);
        @(negedge clk); tmr0_ovf = 1'b1;
        @(negedge clk); tmr0_ovf = 1'b0;
        tick_exp(1'b0, 8'h00, "R6");
        rd_chk(RA, 8'h48, "R6");
        wr(RA, 8'h41);
        tick_exp(1'b0, 8'h00, "R3");
        wr(RA, 8'h49);
        tick_exp(1'b1, 8'h0C, "R6");
        rd_chk(RA, 8'h08, "R6");
        wr(RA, 8'h00);
    endtask

    task automatic t_stack();
        @(negedge clk); stack_full = 1'b1;
        wr(RA, 8'h13);
        tick_exp(1'b0, 8'h00, "R7");
        tick_exp(1'b0, 8'h00, "R7");
        rd_chk(RA, 8'h13, "R7");
        @(negedge clk); stack_full = 1'b0;
        @(negedge clk);
        chk("R7", irq_ack, 1'b0);
        tick_exp(1'b1, 8'h04, "R7");
        wr(RA, 8'h00);
    endtask

    task automatic t_between();
        wr(RB, 8'h08);
        wr(RA, 8'h01);
        tick_exp(1'b0, 8'h00, "R8");
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", irq_ack, 1'b0);
        end
        tick_exp(1'b1, 8'h18, "R8");
    endtask

    task automatic t_ret();
        @(negedge clk); ret_strobe = 1'b1;
        @(negedge clk); ret_strobe = 1'b0;
        rd_chk(RA, 8'h00, "R9");
        @(negedge clk); reti_strobe = 1'b1;
        @(negedge clk); reti_strobe = 1'b0;
        rd_chk(RA, 8'h01, "R9");
        @(negedge clk); ret_strobe = 1'b1;
        @(negedge clk); ret_strobe = 1'b0;
        rd_chk(RA, 8'h01, "R9");
        wr(RA, 8'h00);
        wr(RB, 8'h00);
    endtask

    task automatic t_edge();
        @(negedge clk); ext_pin = 2'b11;
        rd_chk(RA, 8'h10, "R10");
        wr(RA, 8'h00);
        @(negedge clk); ext_pin = 2'b00;
        rd_chk(RA, 8'h20, "R10");
        wr(RA, 8'h00);
        rd_chk(RA, 8'h00, "R10");
    endtask

    task automatic t_hwwin();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RB; reg_wdata = 8'h00; adc_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; adc_done = 1'b0;
        rd_chk(RB, 8'h40, "R11");
        wr(RB, 8'h00);
        rd_chk(RB, 8'h00, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_single();
        t_priority();
        t_masked();
        t_stack();
        t_between();
        t_ret();
        t_edge();
        t_hwwin();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule